// File: doc/BRIEF.md
# Fractional Multiply with Rounding and Saturation

This unit multiplies two signed fixed-point fractions of a selectable element width (8, 16, 32 or 64 bits) and returns a fraction of the same width. It forms the exact double-width product, doubles it so the binary point lines up with the operands, and keeps the upper element-width bits. Those bits are adjusted by one of four rounding modes, using the bits that were shifted out. The rounded value is clamped to the signed range of the element, and a flag reports when clamping happened.

A request is taken with a one-cycle `start` pulse while the unit is idle. The result appears a fixed number of cycles later with a one-cycle `done` pulse. It stays on the outputs until the next request completes. Only the low element-width bits of each operand are used, and the result is zero-filled above the element width.

Top module: `fxmul_round_sat`

## Requirements
- R1: `width_sel` selects the element width SEW: 0 → 8, 1 → 16, 2 → 32, 3 → 64 bits. Each operand is the signed value of its low SEW bits, and bits above SEW have no effect on the result.
- R2: Let D = 2·a·b, formed exactly. The result before clamping is floor(D / 2^SEW) plus a rounding increment of 0 or 1. With `rmode` = 0 (nearest, ties up), the increment is bit SEW-1 of D.
- R3: With `rmode` = 1 (nearest, ties to even), the increment is bit SEW-1 of D AND (any of bits SEW-2..0 of D set OR the truncated value is odd).
- R4: With `rmode` = 2 (truncate toward minus infinity), the increment is 0.
- R5: With `rmode` = 3 (round to odd), the increment is 1 only when the truncated value is even and any of bits SEW-1..0 of D is set.
- R6: When both operands equal the most negative SEW-bit value, the result is the most positive SEW-bit value and `sat` is 1.
- R7: In all other cases the rounded value is clamped to [-2^(SEW-1), 2^(SEW-1)-1]. `sat` is 1 exactly when clamping changed the value, and 0 otherwise.
- R8: Result bits at and above position SEW are zero. The in-range value appears in two's complement in bits SEW-1..0.
- R9: A `start` seen while idle is accepted on that clock edge. `busy` is high for the next two cycles, and `done` is high for exactly one cycle, set by the third edge counted from acceptance.
- R10: `start` while `busy` is high is ignored. It does not change the pending result and does not cause a second `done`.
- R11: `result` and `sat` change only on the edge that raises `done`, and otherwise hold their value.
- R12: While `rst_n` is low at a clock edge, `done`, `busy`, `result` and `sat` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| op_a | input | 64 | First operand, low SEW bits used |
| op_b | input | 64 | Second operand, low SEW bits used |
| width_sel | input | 2 | Element width code |
| rmode | input | 2 | Rounding mode code |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Request in progress |
| result | output | 64 | Rounded, clamped fraction, zero above SEW |
| sat | output | 1 | Saturation occurred |

## Verification
The hardest case to reach from the ports is the exact rounding tie: the discarded half is a lone guard bit with nothing below it. Random operands almost never produce a tie, so the round-to-even and round-to-odd rules would go untested at the point where they differ. Directed operands build exact ties on both odd and even truncated values, and for both signs. The doubly-negative overflow also needs one specific pair of operands, so it is driven at every width. The random operands are biased toward the extreme values of the selected width.

// File: rtl/fxm_pkg.sv
// Shared constants, types and helper functions for the fractional multiplier.
// Assumes element widths are MIN_W shifted left by the width code.
package fxm_pkg;
    localparam int DATA_W = 64;
    localparam int MIN_W  = 8;
    localparam int NUM_W  = $clog2(DATA_W / MIN_W) + 1;
    localparam int SEL_W  = $clog2(NUM_W);
    localparam int PROD_W = 2 * DATA_W;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_RND  = 2'd2
    } state_e;

    // Ones in the low SEW bits for a width code.
    function automatic logic [DATA_W-1:0] width_mask(input logic [SEL_W-1:0] sel);
        logic [PROD_W-1:0] m;
        m = (PROD_W'(1) << (MIN_W << sel)) - PROD_W'(1);
        return m[DATA_W-1:0];
    endfunction

    // Most positive SEW-bit value, zero above SEW.
    function automatic logic [DATA_W-1:0] width_max(input logic [SEL_W-1:0] sel);
        return width_mask(sel) >> 1;
    endfunction
endpackage

// File: rtl/fxm_operand_prep.sv
// Operand preparation: sign-extends the low SEW bits of both operands to the
// full data width and flags the case where both equal the most negative value.
// Assumes sel_i holds a valid width code (all codes are valid by construction).
module fxm_operand_prep
    import fxm_pkg::*;
(
    input  logic [DATA_W-1:0]        a_i,
    input  logic [DATA_W-1:0]        b_i,
    input  logic [SEL_W-1:0]         sel_i,
    output logic signed [DATA_W-1:0] a_o,
    output logic signed [DATA_W-1:0] b_o,
    output logic                     both_min_o
);
    logic signed [DATA_W-1:0] ext_a [NUM_W];
    logic signed [DATA_W-1:0] ext_b [NUM_W];
    logic [NUM_W-1:0]         min_a, min_b;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_W; gi++) begin : g_width
            localparam int SEW = MIN_W << gi;
            localparam int SH  = DATA_W - SEW;
            localparam logic [DATA_W-1:0] MINV = ~((DATA_W'(1) << (SEW - 1)) - DATA_W'(1));
            // Sign-extend the low SEW bits by shifting up then arithmetic down.
            assign ext_a[gi] = $signed(a_i << SH) >>> SH;
            assign ext_b[gi] = $signed(b_i << SH) >>> SH;
            // Detect the most negative value of this width.
            assign min_a[gi] = (ext_a[gi] == MINV);
            assign min_b[gi] = (ext_b[gi] == MINV);
        end
    endgenerate

    // Pick the candidate for the selected width.
    always_comb begin
        a_o        = ext_a[sel_i];
        b_o        = ext_b[sel_i];
        both_min_o = min_a[sel_i] & min_b[sel_i];
    end
endmodule

// File: rtl/fxm_round_clamp.sv
// Rounding and clamping: takes the doubled product, keeps its upper part for
// the selected width, applies the rounding increment from guard, sticky and
// LSB, then clamps to the signed element range. Assumes dbl_i is exact.
module fxm_round_clamp
    import fxm_pkg::*;
(
    input  logic signed [PROD_W-1:0] dbl_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [1:0]               mode_i,
    input  logic                     both_min_i,
    output logic [DATA_W-1:0]        res_o,
    output logic                     sat_o
);
    logic [NUM_W-1:0]         guard_w, sticky_w;
    logic signed [PROD_W-1:0] trunc_w [NUM_W];
    logic signed [PROD_W-1:0] maxv_w  [NUM_W];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_W; gi++) begin : g_width
            localparam int SEW = MIN_W << gi;
            // Guard bit, sticky OR and truncated upper part for this width.
            assign guard_w[gi]  = dbl_i[SEW-1];
            assign sticky_w[gi] = |dbl_i[SEW-2:0];
            assign trunc_w[gi]  = dbl_i >>> SEW;
            assign maxv_w[gi]   = $signed((PROD_W'(1) << (SEW - 1)) - PROD_W'(1));
        end
    endgenerate

    logic signed [PROD_W-1:0] trunc_s, maxv_s, minv_s, rnd_s;
    logic                     g_s, st_s, lsb_s, inc_s;
    logic [DATA_W-1:0]        mask_s;

    // Choose the increment from the rounding mode.
    always_comb begin
        trunc_s = trunc_w[sel_i];
        maxv_s  = maxv_w[sel_i];
        minv_s  = ~maxv_s;
        g_s     = guard_w[sel_i];
        st_s    = sticky_w[sel_i];
        lsb_s   = trunc_s[0];
        unique case (rmode_e'(mode_i))
            RM_NEAR_UP:   inc_s = g_s;
            RM_NEAR_EVEN: inc_s = g_s & (st_s | lsb_s);
            RM_DOWN:      inc_s = 1'b0;
            RM_ODD:       inc_s = ~lsb_s & (g_s | st_s);
            default:      inc_s = 1'b0;
        endcase
        rnd_s = trunc_s + $signed({{(PROD_W-1){1'b0}}, inc_s});
    end

    // Clamp to the element range and mask to the element width.
    always_comb begin
        mask_s = width_mask(sel_i);
        if (both_min_i) begin
            res_o = maxv_s[DATA_W-1:0] & mask_s;
            sat_o = 1'b1;
        end else if (rnd_s > maxv_s) begin
            res_o = maxv_s[DATA_W-1:0] & mask_s;
            sat_o = 1'b1;
        end else if (rnd_s < minv_s) begin
            res_o = minv_s[DATA_W-1:0] & mask_s;
            sat_o = 1'b1;
        end else begin
            res_o = rnd_s[DATA_W-1:0] & mask_s;
            sat_o = 1'b0;
        end
    end
endmodule

// File: rtl/fxmul_round_sat.sv
// Fractional multiply top: accepts a request when idle, multiplies in the
// second cycle, rounds and clamps in the third, and pulses done. Outputs hold
// until the next completion. Assumes start is a level sampled on clk.
module fxmul_round_sat
    import fxm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [SEL_W-1:0]  width_sel,
    input  logic [1:0]        rmode,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              sat
);
    state_e                   state_q;
    logic signed [DATA_W-1:0] a_ext, b_ext, a_q, b_q;
    logic                     both_min_c, both_min_q;
    logic [SEL_W-1:0]         sel_q;
    logic [1:0]               mode_q;
    logic signed [PROD_W-1:0] a_wide, b_wide, prod_q, dbl;
    logic [DATA_W-1:0]        res_c, result_q;
    logic                     sat_c, sat_q, done_q;

    fxm_operand_prep u_prep (
        .a_i        (op_a),
        .b_i        (op_b),
        .sel_i      (width_sel),
        .a_o        (a_ext),
        .b_o        (b_ext),
        .both_min_o (both_min_c)
    );

    // Widen the registered operands with sign and double the product.
    always_comb begin
        a_wide = a_q;
        b_wide = b_q;
        dbl    = prod_q <<< 1;
    end

    fxm_round_clamp u_round (
        .dbl_i      (dbl),
        .sel_i      (sel_q),
        .mode_i     (mode_q),
        .both_min_i (both_min_q),
        .res_o      (res_c),
        .sat_o      (sat_c)
    );

    // Sequencer and pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            a_q        <= '0;
            b_q        <= '0;
            sel_q      <= '0;
            mode_q     <= '0;
            both_min_q <= 1'b0;
            prod_q     <= '0;
            result_q   <= '0;
            sat_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    a_q        <= a_ext;
                    b_q        <= b_ext;
                    sel_q      <= width_sel;
                    mode_q     <= rmode;
                    both_min_q <= both_min_c;
                    state_q    <= ST_MUL;
                end
                ST_MUL: begin
                    prod_q  <= a_wide * b_wide;
                    state_q <= ST_RND;
                end
                ST_RND: begin
                    result_q <= res_c;
                    sat_q    <= sat_c;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done   = done_q;
    assign busy   = (state_q != ST_IDLE);
    assign result = result_q;
    assign sat    = sat_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##2 done);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(sat)));
    // R6
    minmin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RND && both_min_q) |=> (sat && result == width_max(sel_q)));
    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result & ~width_mask(sel_q)) == '0));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(sel_q) && $stable(mode_q)));
endmodule

// File: tb/fxmul_round_sat_test.sv
`timescale 1ns/1ps
module fxmul_round_sat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  width_sel = '0, rmode = '0;
    logic        done, busy, sat;
    logic [63:0] result;
    int          total = 0, bad = 0;

    fxmul_round_sat uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .width_sel(width_sel), .rmode(rmode), .done(done), .busy(busy),
        .result(result), .sat(sat)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                      input logic [1:0] w, input logic [1:0] m,
                                      output logic [63:0] r, output logic s);
        int sew;
        logic signed [63:0]  xa, xb;
        logic signed [127:0] sa, sb, mx, mn, d, t, rr, lowm;
        logic [127:0] msk;
        logic g, st, inc;
        sew  = 8 << w;
        xa   = $signed(a << (64 - sew)) >>> (64 - sew);
        xb   = $signed(b << (64 - sew)) >>> (64 - sew);
        sa   = xa;
        sb   = xb;
        mx   = (128'sd1 <<< (sew - 1)) - 128'sd1;
        mn   = -mx - 128'sd1;
        msk  = (128'd1 << sew) - 128'd1;
        if (sa == mn && sb == mn) begin
            r = mx[63:0] & msk[63:0];
            s = 1'b1;
            return;
        end
        d    = (sa * sb) <<< 1;
        t    = d >>> sew;
        lowm = (128'sd1 <<< (sew - 1)) - 128'sd1;
        g    = d[sew-1];
        st   = (d & lowm) != 0;
        case (m)
            2'd0:    inc = g;
            2'd1:    inc = g & (st | t[0]);
            2'd2:    inc = 1'b0;
            default: inc = ~t[0] & (g | st);
        endcase
        rr = t + (inc ? 128'sd1 : 128'sd0);
        s  = 1'b0;
        if (rr > mx) begin rr = mx; s = 1'b1; end
        else if (rr < mn) begin rr = mn; s = 1'b1; end
        r = rr[63:0] & msk[63:0];
    endfunction

    // One request; optionally pokes start while busy with other operands.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] w, input logic [1:0] m, input bit poke,
                          output logic [63:0] r, output logic s);
        @(negedge clk);
        op_a = a; op_b = b; width_sel = w; rmode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after accept", {63'd0, busy}, 64'd1);
        chk("R9 no early done", {63'd0, done}, 64'd0);
        if (poke) begin
            op_a = ~a; op_b = a ^ b; rmode = ~m; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R9 no done in second cycle", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R9 done after third edge", {63'd0, done}, 64'd1);
        r = result;
        s = sat;
        @(negedge clk);
        chk("R9 done one cycle", {63'd0, done}, 64'd0);
        if (poke) chk("R10 no restart", {63'd0, busy}, 64'd0);
    endtask

    task automatic op_ref(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] w, input logic [1:0] m, input bit poke);
        logic [63:0] r, er;
        logic s, es;
        run_op(a, b, w, m, poke, r, s);
        ref_model(a, b, w, m, er, es);
        chk(req, r, er);
        chk({req, " sat"}, {63'd0, s}, {63'd0, es});
    endtask

    task automatic op_const(input string req, input logic [63:0] a, input logic [63:0] b,
                            input logic [1:0] w, input logic [1:0] m,
                            input logic [63:0] er, input logic es);
        logic [63:0] r;
        logic s;
        run_op(a, b, w, m, 1'b0, r, s);
        chk(req, r, er);
        chk({req, " sat"}, {63'd0, s}, {63'd0, es});
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] keep_r;
        logic keep_s, s0;
        logic [63:0] r0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12
        chk("R12 done reset", {63'd0, done}, 64'd0);
        chk("R12 busy reset", {63'd0, busy}, 64'd0);
        chk("R12 result reset", result, 64'd0);
        chk("R12 sat reset", {63'd0, sat}, 64'd0);
        rst_n = 1'b1;

        // Ties at SEW=8: 0.5*2^-7 doubled gives guard only, truncated even (R2..R5).
        op_const("R2 tie even up",   64'h40, 64'h01, 2'd0, 2'd0, 64'h01, 1'b0);
        op_const("R3 tie even stay", 64'h40, 64'h01, 2'd0, 2'd1, 64'h00, 1'b0);
        op_const("R4 tie even trunc", 64'h40, 64'h01, 2'd0, 2'd2, 64'h00, 1'b0);
        op_const("R5 tie even odd",  64'h40, 64'h01, 2'd0, 2'd3, 64'h01, 1'b0);
        // Truncated odd tie.
        op_const("R2 tie odd up",    64'h40, 64'h03, 2'd0, 2'd0, 64'h02, 1'b0);
        op_const("R3 tie odd even",  64'h40, 64'h03, 2'd0, 2'd1, 64'h02, 1'b0);
        op_const("R4 tie odd trunc", 64'h40, 64'h03, 2'd0, 2'd2, 64'h01, 1'b0);
        op_const("R5 tie odd keep",  64'h40, 64'h03, 2'd0, 2'd3, 64'h01, 1'b0);
        // Negative tie: -0.5 * 2^-7.
        op_const("R2 neg tie up",    64'hC0, 64'h01, 2'd0, 2'd0, 64'h00, 1'b0);
        op_const("R3 neg tie even",  64'hC0, 64'h01, 2'd0, 2'd1, 64'h00, 1'b0);
        op_const("R4 neg tie floor", 64'hC0, 64'h01, 2'd0, 2'd2, 64'hFF, 1'b0);
        op_const("R5 neg tie odd",   64'hC0, 64'h01, 2'd0, 2'd3, 64'hFF, 1'b0);
        // R1: upper bits ignored.
        op_const("R1 upper ignored", 64'hABCD_EF12_3456_7840, 64'hFFFF_0000_1111_2203,
                 2'd0, 2'd0, 64'h02, 1'b0);
        // R6 at every width, R8 zero upper bits.
        op_const("R6 min8",  64'h80, 64'h80, 2'd0, 2'd0, 64'h7F, 1'b1);
        op_const("R6 min16", 64'h8000, 64'h8000, 2'd1, 2'd2, 64'h7FFF, 1'b1);
        op_const("R6 min32", 64'h8000_0000, 64'hFFFF_FFFF_8000_0000, 2'd2, 2'd1,
                 64'h7FFF_FFFF, 1'b1);
        op_const("R6 min64", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, 2'd3,
                 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        // R7 near-limit without clamping; R8 negative masked.
        op_const("R7 min times max", 64'h80, 64'h7F, 2'd0, 2'd0, 64'h81, 1'b0);
        op_const("R8 neg16 masked", 64'h8000, 64'h7FFF, 2'd1, 2'd3, 64'h8001, 1'b0);
        op_const("R7 one64", 64'h4000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 2'd2,
                 64'h3FFF_FFFF_FFFF_FFFF, 1'b0);

        // R10: start while busy with different operands.
        op_ref("R10 poke ignored", 64'h1234, 64'h5678, 2'd1, 2'd0, 1'b1);

        // R11: outputs held while idle and inputs move.
        run_op(64'h71, 64'h65, 2'd0, 2'd1, 1'b0, keep_r, keep_s);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_a = {$urandom, $urandom};
            op_b = {$urandom, $urandom};
        end
        chk("R11 result held", result, keep_r);
        chk("R11 sat held", {63'd0, sat}, {63'd0, keep_s});

        // Random operands biased to extremes, all widths and modes.
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b, mxv;
            logic [1:0] w, m;
            w = 2'($urandom_range(0, 3));
            m = 2'($urandom_range(0, 3));
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            mxv = ((64'd1 << ((8 << w) - 1)) - 64'd1);
            case ($urandom_range(0, 5))
                0: a = ~mxv;
                1: b = mxv;
                2: begin a = ~mxv; b = ~mxv; end
                default: ;
            endcase
            op_ref("R2 R7 random", a, b, w, m, (i % 7) == 0);
        end

        // Mid-stream reset clears outputs (R12).
        run_op(64'h55, 64'h33, 2'd0, 2'd0, 1'b0, r0, s0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 result cleared", result, 64'd0);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule